// File: doc/BRIEF.md
# Peripheral Bus Clock Divider with Ratio-Change Handshake

This block divides its input clock by an integer ratio from 1 to 128 to produce a peripheral bus clock. It is controlled through one 16-bit control word that software writes and reads back. The word carries a divisor field, an output enable and a read-only ready flag. The output is a registered level in the input clock domain. Each output period begins with its high phase, and the high phase never runs longer than the low phase.

Writing the control word stores a pending divisor and clears the ready flag. The divider keeps running at the old ratio until its period counter reaches the end of the current period. At that boundary it loads the pending divisor, samples the enable, and raises ready again. Software can therefore poll the flag to learn when the new ratio is in force. The divisor field always reads back the ratio that is actually running. Changes to the enable also take effect only at a period boundary, so gating the clock on or off never produces a shortened high pulse.

Top module: `periph_clk_div`

## Requirements
- R1: After reset the control word reads 0x8800: divisor field 0 (ratio 1), enable bit 15 set, ready bit 11 set. The output is high.
- R2: Control word layout: bits 6:0 hold the divisor field, and the ratio is the field value plus one. Bit 11 is the ready flag, bit 15 is the enable, and all other bits read as 0. The value written to bit 11 has no effect.
- R3: Every write to the control word clears the ready flag, and the flag reads 0 in the cycle after the write.
- R4: After a write, the ready flag returns to 1 at the first period boundary. This happens within the old ratio's number of input cycles. A write that lands on a boundary cycle defers the update to the following boundary.
- R5: A new divisor is loaded only at a period boundary. The output period that is in progress when the write occurs finishes with the old high and low lengths.
- R6: The divisor field reads back the ratio in force. While ready is 0 it still shows the old value, and once ready is 1 it shows the newly written value.
- R7: For a ratio N ≥ 2, each period starts with floor(N/2) high cycles followed by N − floor(N/2) low cycles. Even ratios therefore give 50% duty. Odd ratios give a high phase one cycle shorter than the low phase.
- R8: With ratio 1 and enable set, the output stays continuously high.
- R9: When enable is cleared, the output goes low and stays low from the next period boundary on. When enable is set again, output resumes at a boundary. No high pulse shorter than floor(N/2) cycles ever appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word value to write |
| rd_data | output | 16 | Current control word: applied divisor, ready, enable |
| clk_out | output | 1 | Divided, gated output clock level |

## Verification
The bench goes after the odd ratios. A design that split the period evenly or put the extra cycle into the high phase would report the wrong high and low run lengths. It writes a new divisor in the middle of a period. A divider that reloaded immediately would cut that period short. It also reads the divisor field while ready is low, where a design returning the pending value would expose the new ratio too early. Gating is toggled at a ratio of 8 and the shortest high pulse is tracked. It checks ratio 1, where a design that handled the degenerate case with its normal duty logic would hold the output low. It also checks ratio 128, where the half-period arithmetic would overflow a field-width comparison.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  parameter int unsigned PCD_DIV_W    = 7;
  parameter int unsigned PCD_DATA_W   = 16;
  parameter int unsigned PCD_READY_POS = 11;
  parameter int unsigned PCD_EN_POS    = 15;

  typedef enum logic [1:0] {
    PH_HIGH = 2'd0,
    PH_LOW  = 2'd1,
    PH_OFF  = 2'd2
  } pcd_phase_e;
endpackage

// File: rtl/pcd_ctrl_reg.sv
module pcd_ctrl_reg #(
  parameter int unsigned DIV_W     = 7,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned READY_POS = 11,
  parameter int unsigned EN_POS    = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              boundary,
  input  logic [DIV_W-1:0]  applied_div,
  output logic [DIV_W-1:0]  pend_div,
  output logic              en_req,
  output logic              ready,
  output logic [DATA_W-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_div <= '0;
      en_req   <= 1'b1;
      ready    <= 1'b1;
    end else begin
      if (wr_en) begin
        pend_div <= wr_data[DIV_W-1:0];
        en_req   <= wr_data[EN_POS];
        ready    <= 1'b0;
      end else if (boundary) begin
        ready <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data                 = '0;
    rd_data[DIV_W-1:0]      = applied_div;
    rd_data[READY_POS]      = ready;
    rd_data[EN_POS]         = en_req;
  end

  // R3: any write leaves ready low on the following cycle
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !ready);
endmodule

// File: rtl/pcd_period_ctr.sv
module pcd_period_ctr #(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] pend_div,
  input  logic             en_req,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] active_div,
  output logic             gate,
  output logic             boundary,
  output logic [DIV_W-1:0] nxt_cnt,
  output logic [DIV_W-1:0] nxt_div,
  output logic             nxt_gate
);
  assign boundary = (cnt == active_div);

  always_comb begin
    if (boundary) begin
      nxt_cnt  = '0;
      nxt_div  = pend_div;
      nxt_gate = en_req;
    end else begin
      nxt_cnt  = cnt + 1'b1;
      nxt_div  = active_div;
      nxt_gate = gate;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      active_div <= '0;
      gate       <= 1'b1;
    end else begin
      cnt        <= nxt_cnt;
      active_div <= nxt_div;
      gate       <= nxt_gate;
    end
  end

  // R5: the counter never runs past the applied period
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
    cnt <= active_div);
endmodule

// File: rtl/pcd_out_stage.sv
module pcd_out_stage
  import pcd_pkg::*;
#(
  parameter int unsigned DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] nxt_cnt,
  input  logic [DIV_W-1:0] nxt_div,
  input  logic             nxt_gate,
  output logic             clk_out
);
  localparam int unsigned RW = DIV_W + 1;

  logic [RW-1:0] ratio;
  logic [RW-1:0] high_len;
  pcd_phase_e    phase;

  assign ratio    = {1'b0, nxt_div} + RW'(1);
  assign high_len = ratio >> 1;

  always_comb begin
    if (!nxt_gate)
      phase = PH_OFF;
    else if (nxt_div == '0)
      phase = PH_HIGH;
    else if ({1'b0, nxt_cnt} < high_len)
      phase = PH_HIGH;
    else
      phase = PH_LOW;
  end

  always_ff @(posedge clk) begin
    if (rst) clk_out <= 1'b1;
    else     clk_out <= (phase == PH_HIGH);
  end
endmodule

// File: rtl/periph_clk_div.sv
module periph_clk_div
  import pcd_pkg::*;
#(
  parameter int unsigned DIV_W     = PCD_DIV_W,
  parameter int unsigned DATA_W    = PCD_DATA_W,
  parameter int unsigned READY_POS = PCD_READY_POS,
  parameter int unsigned EN_POS    = PCD_EN_POS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_out
);
  logic [DIV_W-1:0] pend_div, active_div, cnt, nxt_cnt, nxt_div;
  logic             en_req, ready, gate, boundary, nxt_gate;

  pcd_ctrl_reg #(
    .DIV_W(DIV_W), .DATA_W(DATA_W), .READY_POS(READY_POS), .EN_POS(EN_POS)
  ) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .boundary(boundary), .applied_div(active_div),
    .pend_div(pend_div), .en_req(en_req), .ready(ready), .rd_data(rd_data)
  );

  pcd_period_ctr #(.DIV_W(DIV_W)) u_ctr (
    .clk(clk), .rst(rst), .pend_div(pend_div), .en_req(en_req),
    .cnt(cnt), .active_div(active_div), .gate(gate), .boundary(boundary),
    .nxt_cnt(nxt_cnt), .nxt_div(nxt_div), .nxt_gate(nxt_gate)
  );

  pcd_out_stage #(.DIV_W(DIV_W)) u_out (
    .clk(clk), .rst(rst), .nxt_cnt(nxt_cnt), .nxt_div(nxt_div),
    .nxt_gate(nxt_gate), .clk_out(clk_out)
  );

  // R4: ready comes back only on a period boundary
  p_ready_at_boundary_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(boundary));

  // R6: with ready high, the running ratio equals the stored one
  p_readback_r6: assert property (@(posedge clk) disable iff (rst)
    ready |-> (active_div == pend_div));

  // R7: a high phase begins only at the start of a period
  p_rise_at_start_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out) |-> (cnt == '0));

  // R9: gating switches off only while the output sits in its low phase
  p_gate_off_low_r9: assert property (@(posedge clk) disable iff (rst)
    ($fell(gate) && ($past(active_div) != '0)) |-> !$past(clk_out));
endmodule

// File: tb/tb_periph_clk_div.sv
module tb_periph_clk_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        clk_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // scoreboard
  int    q_hi[$];
  int    q_lo[$];
  string q_tag[$];
  int    resync_req = 0;
  int    mon_state = 0;
  int    min_hi = 1000;
  int    hi_runs = 0;

  periph_clk_div dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_out(clk_out)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // monitor: measures high/low runs, compares against expected queue
  int seen_resync = 0;
  int hi_len = 0, lo_len = 0;
  logic prev_out = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      mon_state = 0;
    end else begin
      if (seen_resync != resync_req) begin
        seen_resync = resync_req;
        mon_state = 0;
        min_hi = 1000;
        hi_runs = 0;
      end
      case (mon_state)
        0: if (clk_out && !prev_out) begin mon_state = 1; hi_len = 1; end
        1: if (clk_out) hi_len++;
           else begin
             mon_state = 2; lo_len = 1; hi_runs++;
             if (hi_len < min_hi) min_hi = hi_len;
           end
        default: if (!clk_out) lo_len++;
           else begin
             if (q_hi.size() != 0) begin
               int eh, el; string t;
               eh = q_hi.pop_front(); el = q_lo.pop_front(); t = q_tag.pop_front();
               chk(hi_len == eh, {t, " high length"}, hi_len, eh);
               chk(lo_len == el, {t, " low length"}, lo_len, el);
             end
             mon_state = 1; hi_len = 1;
           end
      endcase
    end
    prev_out = clk_out;
  end

  task automatic reg_write(input logic [15:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_ready(input int limit, input string tag);
    int n = 0;
    while (!rd_data[11] && n <= limit + 2) begin @(negedge clk); n++; end
    chk(rd_data[11] == 1'b1 && n <= limit, tag, n, limit);
  endtask

  task automatic expect_periods(input int hi, input int lo, input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) begin q_hi.push_back(hi); q_lo.push_back(lo); q_tag.push_back(tag); end
    while (q_hi.size() != 0) @(negedge clk);
  endtask

  task automatic program_div(input int field, input int old_ratio);
    reg_write(16'h8000 | 16'(field));
    chk(rd_data[11] == 1'b0, "R3 ready cleared after write", rd_data[11], 0);
    wait_ready(old_ratio, "R4 ready returns within old period");
    chk(rd_data[6:0] == 7'(field), "R6 readback after ready", rd_data[6:0], field);
    resync_req++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_data == 16'h8800, "R1 reset control word", rd_data, 16'h8800);
    chk(clk_out == 1'b1, "R1 reset output", clk_out, 1);
    begin
      int lows = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (!clk_out) lows++; end
      chk(lows == 0, "R8 ratio 1 output held high", lows, 0);
    end

    program_div(3, 1);   expect_periods(2, 2, 4, "R7 even ratio 4");
    program_div(2, 4);   expect_periods(1, 2, 4, "R7 odd ratio 3");
    program_div(1, 3);   expect_periods(1, 1, 4, "R7 ratio 2");
    program_div(6, 2);   expect_periods(3, 4, 3, "R7 odd ratio 7");
    program_div(127, 7); expect_periods(64, 64, 2, "R2 max ratio 128");

    // R6: pending value is not visible before ready
    reg_write(16'h8007);
    chk(rd_data[11] == 1'b0, "R3 ready cleared", rd_data[11], 0);
    chk(rd_data[6:0] == 7'd127, "R6 old divisor while pending", rd_data[6:0], 127);
    wait_ready(128, "R4 ready within ratio 128 period");
    chk(rd_data[6:0] == 7'd7, "R6 new divisor after ready", rd_data[6:0], 7);

    // R5: write in the middle of a period keeps that period whole
    resync_req++;
    while (mon_state != 1) @(negedge clk);
    q_hi.push_back(4); q_lo.push_back(4); q_tag.push_back("R5 period in progress");
    @(negedge clk); @(negedge clk);
    reg_write(16'h8001);
    while (q_hi.size() != 0) @(negedge clk);
    wait_ready(8, "R4 ready after mid-period write");
    resync_req++;
    expect_periods(1, 1, 2, "R5 new ratio after boundary");

    // R2: bit 11 write has no effect; unused bits read zero
    reg_write(16'hFFFF);
    chk(rd_data[11] == 1'b0, "R2 ready ignores written bit", rd_data[11], 0);
    wait_ready(2, "R4 ready after full write");
    chk(rd_data == 16'h887F, "R2 unused bits read zero", rd_data, 16'h887F);

    // R9: gating on/off without short pulses at ratio 8
    program_div(7, 128);
    expect_periods(4, 4, 1, "R9 before gating");
    reg_write(16'h0007);
    repeat (20) @(negedge clk);
    chk(rd_data[15] == 1'b0, "R9 enable reads clear", rd_data[15], 0);
    begin
      int highs = 0;
      for (int i = 0; i < 30; i++) begin @(negedge clk); if (clk_out) highs++; end
      chk(highs == 0, "R9 output held low when disabled", highs, 0);
    end
    reg_write(16'h8007);
    repeat (40) @(negedge clk);
    chk(hi_runs > 0, "R9 output resumes", hi_runs, 1);
    chk(min_hi == 4, "R9 no shortened high pulse", min_hi, 4);

    // R8 and R9 at ratio 1
    program_div(0, 8);
    repeat (2) @(negedge clk);
    begin
      int lows = 0;
      for (int i = 0; i < 12; i++) begin @(negedge clk); if (!clk_out) lows++; end
      chk(lows == 0, "R8 ratio 1 continuous high", lows, 0);
    end
    reg_write(16'h0000);
    repeat (2) @(negedge clk);
    chk(clk_out == 1'b0, "R9 ratio 1 gated low", clk_out, 0);

    finish_run();
  end
endmodule